// File: doc/BRIEF.md
# Counting Semaphore Unit with FIFO Wait Queues

This block keeps a small bank of integer semaphores that several task cores share. Each core has its own command port. Through it the core asks for a blocking acquire, a release, or a non-blocking try-acquire on one semaphore index. A blocking acquire on a semaphore that holds a positive count takes one unit, and the core carries on. When the count is zero, the core is parked in a first-in first-out wait queue that belongs to that semaphore. It stays parked until another core releases that semaphore, and the release then hands the unit straight to the longest-waiting core.

The unit services at most one command per clock. When several cores present commands at once, it takes them in fixed port order, so every read-modify-write of a count is atomic. Each semaphore has a separate load port that sets its starting count. A count of 1 makes the semaphore a mutex. The count saturates at its largest value. A release at that value raises a sticky overflow flag for that semaphore, and a load of the same semaphore clears the flag.

A core raises its valid line with an operation and an index, and holds it there. The command completes with a one-cycle `done` pulse, and `ok` carries the result in that same cycle. While a core is parked, its `waiting` bit is high and `done` stays low. When the core is resumed, `waiting` falls and `done` with `ok` pulses in the same cycle. The core lowers valid in the cycle in which it sees `done`.

Top module: `sem_unit`

## Requirements
- R1: After reset every semaphore count equals RESET_VAL (default 1), and `done`, `ok`, `waiting` and `overflow` are all low.
- R2: A cycle with `load_valid` high writes `load_value` into semaphore `load_idx` and clears its overflow bit. No core command is serviced in that cycle.
- R3: Operation code 2'b00 (acquire) on a count above zero decrements the count. In the next cycle `done` and `ok` of that core are high.
- R4: An acquire (2'b00) on a count of zero leaves the count at zero and raises the core's `waiting` bit in the next cycle, with no `done` pulse.
- R5: Operation code 2'b01 (release) on a semaphore with no parked cores increments the count and pulses `done` with `ok` high.
- R6: A release on a semaphore with parked cores leaves the count unchanged and resumes the oldest parked core. That core's `waiting` falls and its `done` and `ok` pulse in the same cycle as the releasing core's `done` and `ok`.
- R7: Operation code 2'b10 (try-acquire) pulses `done` in the next cycle. It decrements the count with `ok` high when the count is above zero. Otherwise it leaves the count unchanged with `ok` low, and the core never parks.
- R8: Exactly one eligible command is serviced per clock, and the lowest-numbered core wins. A core is eligible when its valid is high, it is not waiting, and its `done` is not high.
- R9: A release at the maximum count (2^VAL_W-1, 15 by default) with no parked cores leaves the count unchanged, returns `ok` low and sets that semaphore's sticky `overflow` bit.
- R10: Operation code 2'b11 is reserved. It pulses `done` with `ok` low and changes no count.
- R11: `done` lasts exactly one cycle. A core whose `done` is high is not serviced in that cycle, even if its valid is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_CORES | Per-core command valid, held until `done` |
| req_op | input | 2*NUM_CORES | Per-core operation code, core c in bits [2c+1:2c] |
| req_idx | input | NUM_CORES*clog2(NUM_SEMS) | Per-core semaphore index, core c in slice c |
| load_valid | input | 1 | Load a starting count into one semaphore |
| load_idx | input | clog2(NUM_SEMS) | Semaphore to load |
| load_value | input | VAL_W | Count to load |
| done | output | NUM_CORES | One-cycle completion pulse per core |
| ok | output | NUM_CORES | Result, valid with `done` |
| waiting | output | NUM_CORES | Core is parked in a wait queue |
| overflow | output | NUM_SEMS | Sticky saturation flag per semaphore |

## Verification
The bench parks two cores on one mutex and releases it twice. A queue that resumed in last-in order, or resumed nobody, would wake the wrong core or leave both parked. It has four cores try-acquire the same mutex in the same cycle: a unit that served two at once or skipped the port order would grant more than one success, or grant it to the wrong core. It releases a semaphore loaded at its maximum count, where a design that wrapped would show no overflow and a later try-acquire would see a wrong count. It also loads a count in the same cycle as a waiting command, and runs long random traffic in which a core that held valid through its `done` cycle would be served twice.

// File: rtl/sem_pkg.sv
package sem_pkg;

   typedef enum logic [1:0] {
      OP_ACQ  = 2'b00,
      OP_REL  = 2'b01,
      OP_TRY  = 2'b10,
      OP_RSVD = 2'b11
   } sem_op_e;

endpackage

// File: rtl/sem_arb.sv
module sem_arb #(
   parameter int N        = 4,
   parameter bit PICK_LOW = 1'b1
) (
   input  logic [N-1:0]         req,
   output logic                 any,
   output logic [$clog2(N)-1:0] gnt_id
);
   localparam int ID_W = $clog2(N);

   assign any = |req;

   generate
      if (PICK_LOW) begin : g_low
         always_comb begin
            gnt_id = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req[i]) gnt_id = ID_W'(i);
            end
         end
      end else begin : g_high
         always_comb begin
            gnt_id = '0;
            for (int i = 0; i < N; i++) begin
               if (req[i]) gnt_id = ID_W'(i);
            end
         end
      end
   endgenerate

   // R8: a winner must be one of the requesters
   always_comb begin
      if (any) a_gnt_is_req_r8 : assert (req[gnt_id]);
   end

endmodule

// File: rtl/sem_waitq.sv
module sem_waitq #(
   parameter int DEPTH = 4,
   parameter int ID_W  = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  logic [ID_W-1:0] push_id,
   input  logic            pop,
   output logic [ID_W-1:0] head,
   output logic            empty
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [ID_W-1:0]  slot_q [DEPTH];
   logic [PTR_W-1:0] wr_q, rd_q;
   logic [CNT_W-1:0] cnt_q;
   logic             full;

   function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CNT_W'(DEPTH));
   assign head  = slot_q[rd_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
         for (int k = 0; k < DEPTH; k++) slot_q[k] <= '0;
      end else begin
         if (push) begin
            slot_q[wr_q] <= push_id;
            wr_q         <= nxt(wr_q);
         end
         if (pop) rd_q <= nxt(rd_q);
         if (push && !pop) cnt_q <= cnt_q + 1'b1;
         else if (pop && !push) cnt_q <= cnt_q - 1'b1;
      end
   end

   // R4: a core can be parked only once, so the queue never overfills
   p_no_push_full_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   // R6: a release only resumes from a queue that holds a core
   p_no_pop_empty_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/sem_unit.sv
module sem_unit
   import sem_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int NUM_SEMS  = 4,
   parameter int VAL_W     = 4,
   parameter int RESET_VAL = 1,
   parameter bit PICK_LOW  = 1'b1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [NUM_CORES-1:0]                 req_valid,
   input  logic [2*NUM_CORES-1:0]               req_op,
   input  logic [NUM_CORES*$clog2(NUM_SEMS)-1:0] req_idx,
   input  logic                                 load_valid,
   input  logic [$clog2(NUM_SEMS)-1:0]          load_idx,
   input  logic [VAL_W-1:0]                     load_value,
   output logic [NUM_CORES-1:0]                 done,
   output logic [NUM_CORES-1:0]                 ok,
   output logic [NUM_CORES-1:0]                 waiting,
   output logic [NUM_SEMS-1:0]                  overflow
);
   localparam int IDX_W = $clog2(NUM_SEMS);
   localparam int CID_W = $clog2(NUM_CORES);
   localparam logic [VAL_W-1:0] VMAX = {VAL_W{1'b1}};

   // elaboration-time parameter checks
   if (NUM_CORES < 2) begin : g_bad_cores
      $error("sem_unit: NUM_CORES must be at least 2");
   end
   if (NUM_SEMS < 2) begin : g_bad_sems
      $error("sem_unit: NUM_SEMS must be at least 2");
   end
   if (VAL_W < 1 || RESET_VAL < 0 || RESET_VAL > (2 ** VAL_W) - 1) begin : g_bad_val
      $error("sem_unit: RESET_VAL must fit in VAL_W bits");
   end

   logic [VAL_W-1:0] cnt_q  [NUM_SEMS];
   logic [NUM_SEMS-1:0]  ovf_q;
   logic [NUM_CORES-1:0] done_q, ok_q, wait_q;

   sem_op_e          op_c  [NUM_CORES];
   logic [IDX_W-1:0] idx_c [NUM_CORES];

   generate
      for (genvar c = 0; c < NUM_CORES; c++) begin : g_dec
         assign op_c[c]  = sem_op_e'(req_op[2*c +: 2]);
         assign idx_c[c] = req_idx[c*IDX_W +: IDX_W];
      end
   endgenerate

   // arbitration: only idle, non-parked cores compete; a load blocks service
   logic [NUM_CORES-1:0] elig;
   logic                 svc;
   logic [CID_W-1:0]     win;

   assign elig = req_valid & ~wait_q & ~done_q & {NUM_CORES{~load_valid}};

   sem_arb #(.N(NUM_CORES), .PICK_LOW(PICK_LOW)) u_arb (
      .req    (elig),
      .any    (svc),
      .gnt_id (win)
   );

   sem_op_e          w_op;
   logic [IDX_W-1:0] w_idx;
   logic [VAL_W-1:0] w_cnt;

   assign w_op  = op_c[win];
   assign w_idx = idx_c[win];
   assign w_cnt = cnt_q[w_idx];

   // one FIFO wait queue per semaphore
   logic [NUM_SEMS-1:0] q_push, q_pop, q_empty;
   logic [CID_W-1:0]    q_head [NUM_SEMS];

   generate
      for (genvar s = 0; s < NUM_SEMS; s++) begin : g_q
         assign q_push[s] = svc && (w_idx == IDX_W'(s)) && (w_op == OP_ACQ)
                            && (w_cnt == '0);
         assign q_pop[s]  = svc && (w_idx == IDX_W'(s)) && (w_op == OP_REL)
                            && !q_empty[s];
         sem_waitq #(.DEPTH(NUM_CORES), .ID_W(CID_W)) u_waitq (
            .clk     (clk),
            .rst_n   (rst_n),
            .push    (q_push[s]),
            .push_id (win),
            .pop     (q_pop[s]),
            .head    (q_head[s]),
            .empty   (q_empty[s])
         );
      end
   endgenerate

   logic             w_has_wait;
   logic [CID_W-1:0] w_head;

   assign w_has_wait = !q_empty[w_idx];
   assign w_head     = q_head[w_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < NUM_SEMS; k++) cnt_q[k] <= VAL_W'(RESET_VAL);
         ovf_q  <= '0;
         done_q <= '0;
         ok_q   <= '0;
         wait_q <= '0;
      end else begin
         done_q <= '0;
         ok_q   <= '0;
         if (load_valid) begin
            cnt_q[load_idx] <= load_value;
            ovf_q[load_idx] <= 1'b0;
         end else if (svc) begin
            done_q[win] <= 1'b1;
            unique case (w_op)
               OP_ACQ: begin
                  if (w_cnt != '0) begin
                     cnt_q[w_idx] <= w_cnt - 1'b1;
                     ok_q[win]    <= 1'b1;
                  end else begin
                     done_q[win] <= 1'b0;
                     wait_q[win] <= 1'b1;
                  end
               end
               OP_TRY: begin
                  if (w_cnt != '0) begin
                     cnt_q[w_idx] <= w_cnt - 1'b1;
                     ok_q[win]    <= 1'b1;
                  end
               end
               OP_REL: begin
                  if (w_has_wait) begin
                     ok_q[win]      <= 1'b1;
                     done_q[w_head] <= 1'b1;
                     ok_q[w_head]   <= 1'b1;
                     wait_q[w_head] <= 1'b0;
                  end else if (w_cnt == VMAX) begin
                     ovf_q[w_idx] <= 1'b1;
                  end else begin
                     cnt_q[w_idx] <= w_cnt + 1'b1;
                     ok_q[win]    <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign done     = done_q;
   assign ok       = ok_q;
   assign waiting  = wait_q;
   assign overflow = ovf_q;

   generate
      for (genvar c = 0; c < NUM_CORES; c++) begin : g_core_chk
         // R4: a parked core never reports completion
         p_wait_no_done_r4 : assert property (@(posedge clk) disable iff (!rst_n)
            !(wait_q[c] && done_q[c]));
         // R6: leaving the wait queue always comes with a successful completion
         p_resume_ok_r6 : assert property (@(posedge clk) disable iff (!rst_n)
            $fell(wait_q[c]) |-> (done_q[c] && ok_q[c]));
         // R11: a completion pulse lasts one cycle
         p_done_pulse_r11 : assert property (@(posedge clk) disable iff (!rst_n)
            done_q[c] |=> !done_q[c]);
      end
      for (genvar s = 0; s < NUM_SEMS; s++) begin : g_sem_chk
         // R9: the overflow flag only clears through a load of its semaphore
         p_ovf_sticky_r9 : assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ovf_q[s]) |-> ($past(load_valid) && $past(load_idx) == IDX_W'(s)));
         // R8: without a load, a count moves by at most one per clock
         p_step_one_r8 : assert property (@(posedge clk) disable iff (!rst_n)
            !$past(load_valid) |-> ($stable(cnt_q[s])
               || cnt_q[s] == $past(cnt_q[s]) + 1'b1
               || cnt_q[s] == $past(cnt_q[s]) - 1'b1));
      end
   endgenerate

   // R8: one serviced command plus at most one resumed core per clock
   p_two_done_max_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      $countones(done_q) <= 2);

endmodule

// File: tb/sem_unit_tb.sv
module sem_unit_tb;
   localparam int NC   = 4;
   localparam int NS   = 4;
   localparam int VW   = 4;
   localparam int IW   = 2;
   localparam int VMAX = 15;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [NC-1:0]   req_valid;
   logic [2*NC-1:0] req_op;
   logic [NC*IW-1:0] req_idx;
   logic            load_valid;
   logic [IW-1:0]   load_idx;
   logic [VW-1:0]   load_value;
   logic [NC-1:0]   done, ok, waiting;
   logic [NS-1:0]   overflow;

   always #2 clk = ~clk;

   sem_unit u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_idx(req_idx), .load_valid(load_valid), .load_idx(load_idx),
      .load_value(load_value), .done(done), .ok(ok), .waiting(waiting),
      .overflow(overflow)
   );

   int n_chk = 0;
   int n_bad = 0;

   // reference model
   int    m_cnt [NS];
   int    m_q   [NS][NC];
   int    m_qn  [NS];
   bit    m_ovf [NS];
   bit    e_done[NC], e_ok[NC], e_wait[NC];
   string e_tag [NC];

   // driver state
   bit v[NC];
   int op[NC], ix[NC];
   bit d_req[NC];
   int d_op[NC], d_ix[NC];
   bit d_load;
   int d_lidx, d_lval;
   bit rand_en;
   bit ld;
   int ld_idx, ld_val;

   task automatic chk(input bit act, input bit exp, input string tag, input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic issue(input int c, input int o, input int s);
      d_req[c] = 1'b1; d_op[c] = o; d_ix[c] = s;
   endtask

   task automatic model_step();
      bit nd[NC];
      bit nk[NC];
      int sel;
      sel = -1;
      for (int c = 0; c < NC; c++) begin
         nd[c] = 0; nk[c] = 0;
         e_tag[c] = ld ? "R2" : (e_done[c] ? "R11" : "R8");
      end
      if (ld) begin
         m_cnt[ld_idx] = ld_val;
         m_ovf[ld_idx] = 0;
      end else begin
         for (int c = 0; c < NC; c++)
            if (sel < 0 && v[c] && !e_wait[c] && !e_done[c]) sel = c;
      end
      if (sel >= 0) begin
         int s;
         s = ix[sel];
         case (op[sel])
            0: begin
               if (m_cnt[s] > 0) begin
                  m_cnt[s]--; nd[sel] = 1; nk[sel] = 1; e_tag[sel] = "R3";
               end else begin
                  m_q[s][m_qn[s]] = sel; m_qn[s]++; e_wait[sel] = 1; e_tag[sel] = "R4";
               end
            end
            2: begin
               nd[sel] = 1; e_tag[sel] = "R7";
               if (m_cnt[s] > 0) begin m_cnt[s]--; nk[sel] = 1; end
            end
            1: begin
               nd[sel] = 1;
               if (m_qn[s] > 0) begin
                  int h;
                  h = m_q[s][0];
                  for (int k = 0; k < NC - 1; k++) m_q[s][k] = m_q[s][k+1];
                  m_qn[s]--;
                  nd[h] = 1; nk[h] = 1; e_wait[h] = 0; e_tag[h] = "R6";
                  nk[sel] = 1; e_tag[sel] = "R6";
               end else if (m_cnt[s] == VMAX) begin
                  m_ovf[s] = 1; e_tag[sel] = "R9";
               end else begin
                  m_cnt[s]++; nk[sel] = 1; e_tag[sel] = "R5";
               end
            end
            default: begin
               nd[sel] = 1; e_tag[sel] = "R10";
            end
         endcase
      end
      for (int c = 0; c < NC; c++) begin e_done[c] = nd[c]; e_ok[c] = nk[c]; end
   endtask

   task automatic step();
      int nw;
      @(negedge clk);
      for (int c = 0; c < NC; c++) begin
         chk(done[c], e_done[c], e_tag[c], $sformatf("done core %0d", c));
         chk(ok[c], e_ok[c], e_tag[c], $sformatf("ok core %0d", c));
         chk(waiting[c], e_wait[c], "R4", $sformatf("waiting core %0d", c));
      end
      for (int s = 0; s < NS; s++)
         chk(overflow[s], m_ovf[s], "R9", $sformatf("overflow sem %0d", s));
      nw = 0;
      for (int c = 0; c < NC; c++) if (waiting[c]) nw++;
      for (int c = 0; c < NC; c++) begin
         if (done[c]) v[c] = 0;
         else if (!v[c] && !waiting[c]) begin
            if (d_req[c]) begin
               v[c] = 1; op[c] = d_op[c]; ix[c] = d_ix[c]; d_req[c] = 0;
            end else if (rand_en && ($urandom % 3 == 0)) begin
               v[c] = 1;
               op[c] = $urandom % 4;
               ix[c] = $urandom % NS;
               if (nw >= NC - 1) begin
                  op[c] = 1;
                  for (int s = 0; s < NS; s++) if (m_qn[s] > 0) ix[c] = s;
               end
            end
         end
      end
      ld = 0;
      if (d_load) begin
         ld = 1; ld_idx = d_lidx; ld_val = d_lval; d_load = 0;
      end else if (rand_en && ($urandom % 40 == 0)) begin
         ld = 1; ld_idx = $urandom % NS;
         ld_val = ($urandom % 8 == 0) ? VMAX : int'($urandom % 3);
      end
      for (int c = 0; c < NC; c++) begin
         req_valid[c]      = v[c];
         req_op[2*c +: 2]  = 2'(op[c]);
         req_idx[c*IW +: IW] = IW'(ix[c]);
      end
      load_valid = ld;
      load_idx   = IW'(ld_idx);
      load_value = VW'(ld_val);
      model_step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      rst_n = 1'b0; req_valid = '0; req_op = '0; req_idx = '0;
      load_valid = 1'b0; load_idx = '0; load_value = '0;
      rand_en = 0; d_load = 0; ld = 0; ld_idx = 0; ld_val = 0;
      for (int s = 0; s < NS; s++) begin m_cnt[s] = 1; m_qn[s] = 0; m_ovf[s] = 0; end
      for (int c = 0; c < NC; c++) begin
         v[c] = 0; op[c] = 0; ix[c] = 0; d_req[c] = 0;
         e_done[c] = 0; e_ok[c] = 0; e_wait[c] = 0; e_tag[c] = "R8";
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state at the ports
      chk(|done, 1'b0, "R1", "done after reset");
      chk(|ok, 1'b0, "R1", "ok after reset");
      chk(|waiting, 1'b0, "R1", "waiting after reset");
      chk(|overflow, 1'b0, "R1", "overflow after reset");

      // R3/R4/R6: mutex on sem 0, two cores park, resumed oldest first
      issue(0, 0, 0); step();
      issue(1, 0, 0); step();
      issue(2, 0, 0); step();
      issue(3, 2, 0); step();   // R7: try-acquire fails on zero count
      repeat (3) step();
      issue(0, 1, 0); step(); repeat (2) step();
      issue(1, 1, 0); step(); repeat (2) step();
      issue(2, 1, 0); step(); repeat (3) step();
      // R8: four simultaneous try-acquires on sem 1, only core 0 succeeds
      for (int c = 0; c < NC; c++) issue(c, 2, 1);
      step(); repeat (6) step();
      // R9: release at maximum count sets overflow
      d_load = 1; d_lidx = 2; d_lval = VMAX; step();
      issue(0, 1, 2); step(); repeat (3) step();
      // R2: load clears overflow and blocks service in its cycle
      d_load = 1; d_lidx = 2; d_lval = 0; issue(3, 2, 2); step(); repeat (3) step();
      // R10: reserved operation
      issue(1, 3, 1); step(); repeat (3) step();

      // constrained random traffic
      rand_en = 1;
      repeat (4000) step();
      rand_en = 0;
      repeat (40) step();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule